// File: doc/BRIEF.md
# Add/Subtract Unit with Carry Chaining

This block is the integer add/subtract datapath of a processor execute stage. It forms a result from a first operand and a second operand using one of five operations: plain add, add with the carry flag, plain subtract, subtract with the carry flag taken as an inverted borrow, and reverse subtract. The second operand is either a full-width register value or a small zero-extended immediate. The immediate is accepted only by plain add and plain subtract.

The result and the destination register index come straight from the inputs, with no register in between. The four condition flags sit in a clocked register. That register is written on the edge that follows a valid, legal operation whose set-flags input is high. Otherwise the flags keep their value. Because the carry flag feeds back into the two carry operations, words wider than the datapath can be added or subtracted one slice at a time, starting with the least significant slice.

Top module: `addsub_carry_unit`

## Requirements
- R1: Opcode 0 (add) gives `a_i + op2`. Here `op2` is `b_i` when `use_imm_i` is 0, and the zero-extended `imm_i` when it is 1. The result is taken modulo 2^DATA_W.
- R2: Opcode 1 (add with carry) gives `a_i + b_i + C`, where C is the registered carry flag.
- R3: Opcode 2 (subtract) gives `a_i - op2`, with `op2` chosen as in R1.
- R4: Opcode 3 (subtract with carry) gives `a_i - b_i`, less one when the registered carry flag is 0.
- R5: Opcode 4 (reverse subtract) gives `b_i - a_i`.
- R6: `illegal_o` is 1 when `use_imm_i` is 1 with any opcode other than 0 or 2, and for opcodes 5 to 7. An illegal operation drives `result_o` to zero and leaves the flags unchanged.
- R7: The flags change only on a clock edge where `valid_i` and `set_flags_i` are both 1 and the operation is legal. At every other edge they hold.
- R8: `flags_o` is {N, Z, C, V} from bit 3 down to bit 0. N is the top result bit. Z is 1 when the result is all zeros.
- R9: For an add, C is the carry out of the top bit. For a subtract, C is 1 when no borrow occurs (minuend ≥ subtrahend + borrow-in).
- R10: V is 1 when the signed result of the operation lies outside the signed DATA_W-bit range.
- R11: `dest_idx_o` equals `rd_idx_i` when `rd_given_i` is 1, and `rn_idx_i` otherwise.
- R12: While `rst` is high at a clock edge, the flags are cleared to zero.
- R13: An add followed by add with carry, both setting flags, produces a correct sum twice the datapath width. A subtract followed by subtract with carry does the same for a difference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 3 | Opcode (0 to 4 legal) |
| set_flags_i | input | 1 | Write the flags from this operation |
| use_imm_i | input | 1 | Take the second operand from the immediate |
| a_i | input | DATA_W | First operand |
| b_i | input | DATA_W | Register second operand |
| imm_i | input | IMM_W | Unsigned immediate |
| rn_idx_i | input | IDX_W | First-operand register index |
| rd_idx_i | input | IDX_W | Explicit destination index |
| rd_given_i | input | 1 | The explicit destination is present |
| result_o | output | DATA_W | Operation result |
| dest_idx_o | output | IDX_W | Register index that receives the result |
| illegal_o | output | 1 | Illegal opcode or immediate combination |
| flags_o | output | 4 | {N, Z, C, V} |

## Verification
The bench builds the unit with DATA_W = 8, IMM_W = 4 and IDX_W = 3. At this width every pair of operands can be swept through every legal opcode, with the carry flag both clear and set. Every immediate value can also be paired with every first operand, and every opcode and immediate combination can be tried for legality. The flags are checked after clocked operations on a strided grid of operands. The 8-bit width also lets 16-bit chained sums and differences be compared against plain integer arithmetic.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBC = 3'd3,
        OP_RSB = 3'd4
    } addsub_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } cond_flags_t;

endpackage

// File: rtl/addsub_operand_sel.sv
module addsub_operand_sel
    import addsub_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 12
) (
    input  logic [2:0]        op_i,
    input  logic              use_imm_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              carry_i,
    output logic [DATA_W-1:0] x_o,
    output logic [DATA_W-1:0] y_o,
    output logic              cin_o,
    output logic              illegal_o
);
    localparam int PAD_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] op2;

    always_comb begin
        op2       = use_imm_i ? {{PAD_W{1'b0}}, imm_i} : b_i;
        x_o       = a_i;
        y_o       = op2;
        cin_o     = 1'b0;
        illegal_o = 1'b0;
        case (op_i)
            OP_ADD: begin
                y_o   = op2;
                cin_o = 1'b0;
            end
            OP_ADC: begin
                y_o       = b_i;
                cin_o     = carry_i;
                illegal_o = use_imm_i;
            end
            OP_SUB: begin
                y_o   = ~op2;
                cin_o = 1'b1;
            end
            OP_SBC: begin
                y_o       = ~b_i;
                cin_o     = carry_i;
                illegal_o = use_imm_i;
            end
            OP_RSB: begin
                x_o       = b_i;
                y_o       = ~a_i;
                cin_o     = 1'b1;
                illegal_o = use_imm_i;
            end
            default: illegal_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/addsub_adder.sv
module addsub_adder
    import addsub_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] y_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] sum_o,
    output cond_flags_t       flags_o
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] wide;

    always_comb begin
        wide       = {1'b0, x_i} + {1'b0, y_i} + {{DATA_W{1'b0}}, cin_i};
        sum_o      = wide[MSB:0];
        flags_o.n  = wide[MSB];
        flags_o.z  = (wide[MSB:0] == '0);
        flags_o.c  = wide[DATA_W];
        flags_o.v  = (x_i[MSB] == y_i[MSB]) && (wide[MSB] != x_i[MSB]);
    end
endmodule

// File: rtl/addsub_flag_reg.sv
module addsub_flag_reg
    import addsub_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en_i,
    input  cond_flags_t flags_i,
    output cond_flags_t flags_o
);
    cond_flags_t flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (wr_en_i) begin
            flags_d = flags_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags_o = flags_q;
endmodule

// File: rtl/addsub_carry_unit.sv
module addsub_carry_unit
    import addsub_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 12,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [2:0]        op_i,
    input  logic              set_flags_i,
    input  logic              use_imm_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [IDX_W-1:0]  rn_idx_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    input  logic              rd_given_i,
    output logic [DATA_W-1:0] result_o,
    output logic [IDX_W-1:0]  dest_idx_o,
    output logic              illegal_o,
    output logic [3:0]        flags_o
);
    logic [DATA_W-1:0] x, y, sum;
    logic              cin, illegal;
    cond_flags_t       new_flags, cur_flags;

    addsub_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sel (
        .op_i      (op_i),
        .use_imm_i (use_imm_i),
        .a_i       (a_i),
        .b_i       (b_i),
        .imm_i     (imm_i),
        .carry_i   (cur_flags.c),
        .x_o       (x),
        .y_o       (y),
        .cin_o     (cin),
        .illegal_o (illegal)
    );

    addsub_adder #(.DATA_W(DATA_W)) u_add (
        .x_i     (x),
        .y_i     (y),
        .cin_i   (cin),
        .sum_o   (sum),
        .flags_o (new_flags)
    );

    addsub_flag_reg u_flags (
        .clk     (clk),
        .rst     (rst),
        .wr_en_i (valid_i && set_flags_i && !illegal),
        .flags_i (new_flags),
        .flags_o (cur_flags)
    );

    assign result_o   = illegal ? '0 : sum;
    assign dest_idx_o = rd_given_i ? rd_idx_i : rn_idx_i;
    assign illegal_o  = illegal;
    assign flags_o    = cur_flags;
endmodule

// File: rtl/addsub_carry_unit_chk.sv
module addsub_carry_unit_chk #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              valid_i,
    input logic [2:0]        op_i,
    input logic              set_flags_i,
    input logic              use_imm_i,
    input logic [DATA_W-1:0] result_o,
    input logic [IDX_W-1:0]  rn_idx_i,
    input logic [IDX_W-1:0]  rd_idx_i,
    input logic              rd_given_i,
    input logic [IDX_W-1:0]  dest_idx_o,
    input logic              illegal_o,
    input logic [3:0]        flags_o
);
    logic wr;
    assign wr = valid_i && set_flags_i && !illegal_o;

    p_flags_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(flags_o));

    p_zero_flag_r8: assert property (@(posedge clk) disable iff (rst)
        wr |=> flags_o[2] == ($past(result_o) == '0));

    p_neg_flag_r8: assert property (@(posedge clk) disable iff (rst)
        wr |=> flags_o[3] == $past(result_o[DATA_W-1]));

    p_illegal_zero_r6: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> result_o == '0);

    p_imm_only_add_sub_r6: assert property (@(posedge clk) disable iff (rst)
        (use_imm_i && op_i != 3'd0 && op_i != 3'd2) |-> illegal_o);

    p_dest_default_r11: assert property (@(posedge clk) disable iff (rst)
        !rd_given_i |-> dest_idx_o == rn_idx_i);

    p_dest_given_r11: assert property (@(posedge clk) disable iff (rst)
        rd_given_i |-> dest_idx_o == rd_idx_i);

    p_reset_clear_r12: assert property (@(posedge clk)
        rst |=> flags_o == 4'b0000);
endmodule

bind addsub_carry_unit addsub_carry_unit_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .valid_i     (valid_i),
    .op_i        (op_i),
    .set_flags_i (set_flags_i),
    .use_imm_i   (use_imm_i),
    .result_o    (result_o),
    .rn_idx_i    (rn_idx_i),
    .rd_idx_i    (rd_idx_i),
    .rd_given_i  (rd_given_i),
    .dest_idx_o  (dest_idx_o),
    .illegal_o   (illegal_o),
    .flags_o     (flags_o)
);

// File: tb/addsub_carry_unit_tb.sv
module addsub_carry_unit_tb;
    localparam int W  = 8;
    localparam int IW = 4;
    localparam int XW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          valid_i = 1'b0;
    logic [2:0]    op_i = 3'd0;
    logic          set_flags_i = 1'b0;
    logic          use_imm_i = 1'b0;
    logic [W-1:0]  a_i = '0;
    logic [W-1:0]  b_i = '0;
    logic [IW-1:0] imm_i = '0;
    logic [XW-1:0] rn_idx_i = '0;
    logic [XW-1:0] rd_idx_i = '0;
    logic          rd_given_i = 1'b0;
    logic [W-1:0]  result_o;
    logic [XW-1:0] dest_idx_o;
    logic          illegal_o;
    logic [3:0]    flags_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    addsub_carry_unit #(.DATA_W(W), .IMM_W(IW), .IDX_W(XW)) u_dut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i),
        .set_flags_i(set_flags_i), .use_imm_i(use_imm_i), .a_i(a_i), .b_i(b_i),
        .imm_i(imm_i), .rn_idx_i(rn_idx_i), .rd_idx_i(rd_idx_i),
        .rd_given_i(rd_given_i), .result_o(result_o), .dest_idx_o(dest_idx_o),
        .illegal_o(illegal_o), .flags_o(flags_o)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference: returns {flags[3:0], result[7:0]} computed with integers
    function automatic int model(input int op, input int a, input int b, input int c);
        int raw, sres, sa, sb, res, cf, vf;
        sa = (a >= 128) ? a - 256 : a;
        sb = (b >= 128) ? b - 256 : b;
        case (op)
            0: begin raw = a + b;          sres = sa + sb;          cf = (raw >= 256); end
            1: begin raw = a + b + c;      sres = sa + sb + c;      cf = (raw >= 256); end
            2: begin raw = a - b;          sres = sa - sb;          cf = (raw >= 0);   end
            3: begin raw = a - b - (1-c);  sres = sa - sb - (1-c);  cf = (raw >= 0);   end
            default: begin raw = b - a;    sres = sb - sa;          cf = (raw >= 0);   end
        endcase
        res = raw & 255;
        vf  = (sres > 127 || sres < -128) ? 1 : 0;
        return ((res >= 128 ? 1 : 0) << 11) | ((res == 0 ? 1 : 0) << 10) |
               (cf << 9) | (vf << 8) | res;
    endfunction

    function automatic string req_of(input int op);
        case (op)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            default: return "R5";
        endcase
    endfunction

    // clocked op with flag write, issued at a negedge; returns after next negedge
    task automatic clk_op(input int op, input int a, input int b, input bit sf);
        @(negedge clk);
        valid_i = 1'b1; set_flags_i = sf; use_imm_i = 1'b0;
        op_i = op[2:0]; a_i = a[W-1:0]; b_i = b[W-1:0];
        @(negedge clk);
        valid_i = 1'b0; set_flags_i = 1'b0;
    endtask

    task automatic set_carry(input int c);
        clk_op(0, 255, c, 1'b1);
    endtask

    initial begin : watchdog
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=done", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        int e, cur_c;
        repeat (3) @(negedge clk);
        check("R12 reset flags", flags_o, 0);
        rst = 1'b0;

        // R1..R5: exhaustive operands, carry clear and set, results only
        for (int c = 0; c < 2; c++) begin
            set_carry(c);
            check("R9 carry preset", flags_o[1], c);
            for (int op = 0; op < 5; op++) begin
                op_i = op[2:0];
                for (int a = 0; a < 256; a++) begin
                    for (int b = 0; b < 256; b++) begin
                        a_i = a[W-1:0]; b_i = b[W-1:0];
                        #1;
                        e = model(op, a, b, c);
                        check(req_of(op), result_o, e & 255);
                    end
                end
            end
        end

        // R1 / R3 with immediate: every a against every immediate
        @(negedge clk);
        use_imm_i = 1'b1;
        b_i = 8'hA5;
        for (int op = 0; op < 3; op += 2) begin
            op_i = op[2:0];
            for (int a = 0; a < 256; a++) begin
                for (int im = 0; im < 16; im++) begin
                    a_i = a[W-1:0]; imm_i = im[IW-1:0];
                    #1;
                    e = model(op, a, im, 0);
                    check(op == 0 ? "R1 imm" : "R3 imm", result_o, e & 255);
                    check("R6 imm legal", illegal_o, 0);
                end
            end
        end

        // R6: legality map for all opcodes and immediate selections
        for (int op = 0; op < 8; op++) begin
            for (int ui = 0; ui < 2; ui++) begin
                op_i = op[2:0]; use_imm_i = ui[0]; a_i = 8'h3C; imm_i = 4'h7;
                #1;
                check("R6 illegal flag", illegal_o,
                      (op > 4 || (ui == 1 && op != 0 && op != 2)) ? 1 : 0);
                if (op > 4 || (ui == 1 && op != 0 && op != 2))
                    check("R6 result zero", result_o, 0);
            end
        end
        use_imm_i = 1'b0;

        // R6: illegal op with set-flags leaves the flags alone
        set_carry(1);
        e = flags_o;
        @(negedge clk);
        valid_i = 1'b1; set_flags_i = 1'b1; op_i = 3'd6; a_i = 0; b_i = 0;
        @(negedge clk);
        check("R6 flags unchanged", flags_o, e);
        valid_i = 1'b1; set_flags_i = 1'b1; op_i = 3'd4; use_imm_i = 1'b1;
        @(negedge clk);
        check("R6 imm flags unchanged", flags_o, e);
        valid_i = 1'b0; set_flags_i = 1'b0; use_imm_i = 1'b0;

        // R8 R9 R10: flags over a strided grid, both carry states
        for (int c = 0; c < 2; c++) begin
            for (int op = 0; op < 5; op++) begin
                for (int a = 0; a < 256; a += 17) begin
                    for (int b = 0; b < 256; b += 15) begin
                        set_carry(c);
                        clk_op(op, a, b, 1'b1);
                        e = model(op, a, b, c);
                        check("R8 R9 R10 flags", flags_o, (e >> 8) & 15);
                    end
                end
            end
        end
        // corner operands
        set_carry(0);
        clk_op(0, 127, 1, 1'b1);
        check("R10 pos overflow", flags_o, 4'b1001);
        clk_op(2, 128, 1, 1'b1);
        check("R10 neg overflow", flags_o, 4'b0011);
        clk_op(0, 255, 1, 1'b1);
        check("R9 carry wrap", flags_o, 4'b0110);
        clk_op(2, 0, 1, 1'b1);
        check("R9 borrow", flags_o, 4'b1000);

        // R7: no write without set_flags, or without valid
        set_carry(1);
        e = flags_o;
        clk_op(2, 0, 1, 1'b0);
        check("R7 hold no set", flags_o, e);
        @(negedge clk);
        valid_i = 1'b0; set_flags_i = 1'b1; op_i = 3'd2; a_i = 0; b_i = 1;
        @(negedge clk);
        check("R7 hold no valid", flags_o, e);
        set_flags_i = 1'b0;

        // R11: destination selection
        for (int g = 0; g < 2; g++) begin
            for (int n = 0; n < 8; n++) begin
                rd_given_i = g[0]; rn_idx_i = n[XW-1:0]; rd_idx_i = 3'(7 - n);
                #1;
                check("R11 dest", dest_idx_o, g ? 7 - n : n);
            end
        end

        // R13: 16-bit chained add and subtract
        for (int x = 0; x < 65536; x += 4093) begin
            for (int y = 0; y < 65536; y += 3571) begin
                int lo, hi;
                clk_op(0, x & 255, y & 255, 1'b1);
                lo = 0;
                @(negedge clk);
                op_i = 3'd0; a_i = 8'(x); b_i = 8'(y); #1; lo = result_o;
                valid_i = 1'b1; set_flags_i = 1'b1;
                @(negedge clk);
                op_i = 3'd1; a_i = 8'(x >> 8); b_i = 8'(y >> 8); #1; hi = result_o;
                check("R13 add chain", (hi << 8) | lo, (x + y) & 16'hFFFF);
                op_i = 3'd2; a_i = 8'(x); b_i = 8'(y);
                @(negedge clk);
                op_i = 3'd3; a_i = 8'(x >> 8); b_i = 8'(y >> 8); #1;
                lo = (x - y) & 255;
                hi = result_o;
                check("R13 sub chain", (hi << 8) | lo, (x - y) & 16'hFFFF);
                valid_i = 1'b0; set_flags_i = 1'b0;
            end
        end

        // R12: reset mid-run clears flags
        set_carry(1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R12 reset clears", flags_o, 0);
        rst = 1'b0;
        cur_c = 0;

        $display("CHECKS %0d ERRORS %0d", checks, errors + cur_c);
        $finish;
    end
endmodule